// File: doc/BRIEF.md
# Data Acquisition Sequencing Controller

This block is the digital control for a 16-input sampling converter. It keeps a 4-bit channel address register that selects which analog input the multiplexer connects. The register can take a new address, step to the next channel, or return to channel 0, and it changes only when the start strobe goes low. A rising strobe starts one measurement: a fixed acquisition window and then a successive-approximation conversion. During the conversion the block drives a trial code to an external comparator and reads back one decision bit per clock, most significant bit first.

The 12-bit result is held in a register. It is read as three 4-bit groups, and each group has its own active-low read enable. One flag shows when a measurement is in progress. The analog chain (amplifier, sample-hold, reference, output pads) lies outside the block. Each group therefore gives out a plain drive-enable in place of a high-impedance state. Every timing value is counted in clock cycles.

Top module: `daq_seq_ctrl`

## Requirements
- R1: After reset, `chan_addr` is 0, `busy` is 0, `dac_code` is 0 and the stored result is 0, so `rd_data` reads 0 with all groups enabled.
- R2: When the strobe is seen rising while the block is idle, `busy` goes high on the next clock edge. It stays high for exactly ACQ_CYC + CONV_CYC cycles: the acquisition window first, then the conversion window.
- R3: When the strobe is seen falling with `clear_n`=1 and `load_n`=0, `chan_addr` takes the value of `addr_in`, read as straight binary. At no other time does the register change.
- R4: When the strobe is seen falling with `clear_n`=1 and `load_n`=1, the channel advances by one. It wraps from 15 to 0. With DIFF_MODE=1 it wraps from 7 to 0, and any value of 7 or more steps to 0.
- R5: When the strobe is seen falling with `clear_n`=0, the channel becomes 0 whatever the values of `load_n` and `addr_in`.
- R6: `chan_addr` always shows the channel register. When `mux_en`=1, `chan_sel` is one-hot with bit `chan_addr` set. When `mux_en`=0, `chan_sel` is all zero.
- R7: In the first conversion cycle `dac_code` is 0x800. After each clock in which a bit is under test, that bit stays set if `cmp_in`=1 and is cleared if `cmp_in`=0, and the next lower bit is then set. When the block is not converting, `dac_code` is 0. With a comparator that returns (input >= `dac_code`), the stored result equals the input value.
- R8: A strobe rising edge that arrives while `busy` is high does not restart the measurement, does not lengthen it and does not change its result.
- R9: The stored result changes only when a measurement completes. `rd_data[11:8]` (MSB group, enabled by `rd_en_n[2]`=0), `rd_data[7:4]` (`rd_en_n[1]`) and `rd_data[3:0]` (`rd_en_n[0]`) each show their part of the stored result, and read 0 when their enable is 1. `rd_drive[i]` is the inverse of `rd_en_n[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe | input | 1 | Start strobe: rising edge starts a measurement, falling edge updates the channel |
| load_n | input | 1 | 0 = take `addr_in`, 1 = step to the next channel |
| clear_n | input | 1 | 0 = force channel 0 on the next falling strobe |
| addr_in | input | 4 | Random channel address |
| mux_en | input | 1 | Channel select enable, active high |
| cmp_in | input | 1 | Comparator decision: analog input >= `dac_code` |
| chan_addr | output | 4 | Current channel register |
| chan_sel | output | 16 | One-hot channel select |
| busy | output | 1 | 1 during acquisition and conversion, 0 when the result is complete |
| dac_code | output | 12 | Trial code driven to the comparator |
| rd_en_n | input | 3 | Active-low read enables per 4-bit group (bit 2 = MSB group) |
| rd_data | output | 12 | Gated result groups |
| rd_drive | output | 3 | Drive-enable per group |

## Verification
The assertions assume that `addr_in`, `load_n` and `clear_n` hold steady in the cycle where a falling strobe is detected. They also assume that `cmp_in` reflects the current `dac_code` within the same cycle. The stimulus sets the address and mode inputs five clock cycles before the strobe rises and keeps them until after it falls. It holds the strobe high for four cycles. This matches the rules of a minimum strobe width of 40 ns and a setup time of 50 ns. The comparator is modelled in the stimulus as a combinational comparison against a fixed input value. That value is changed only while the block is idle.

// File: rtl/daq_seq_pkg.sv
package daq_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2
  } phase_e;

  // Next channel in sequential mode, wrapping after last_ch.
  function automatic int unsigned chan_after(int unsigned cur, int unsigned last_ch);
    return (cur >= last_ch) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/daq_chan_reg.sv
module daq_chan_reg #(
  parameter int unsigned CH_W      = 4,
  parameter bit          DIFF_MODE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb_fall,
  input  logic            load_n,
  input  logic            clear_n,
  input  logic [CH_W-1:0] addr_in,
  output logic [CH_W-1:0] chan
);
  import daq_seq_pkg::*;

  localparam int unsigned LAST_CH = DIFF_MODE ? (1 << (CH_W - 1)) - 1 : (1 << CH_W) - 1;

  logic [CH_W-1:0] chan_q;
  logic [CH_W-1:0] chan_seq;

  assign chan_seq = CH_W'(chan_after(int'(chan_q), LAST_CH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
    end else if (stb_fall) begin
      if (!clear_n)     chan_q <= '0;
      else if (!load_n) chan_q <= addr_in;
      else              chan_q <= chan_seq;
    end
  end

  assign chan = chan_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && !clear_n) |=> (chan == '0)); // R5
  AST_RANDOM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && clear_n && !load_n) |=> (chan == $past(addr_in))); // R3
  AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_fall |=> $stable(chan)); // R3
  AST_SEQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && clear_n && load_n) |=> (int'(chan) <= LAST_CH)); // R4

endmodule

// File: rtl/daq_phase_ctrl.sv
module daq_phase_ctrl #(
  parameter int unsigned ACQ_CYC  = 20,
  parameter int unsigned CONV_CYC = 16,
  parameter int unsigned RES_BITS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_rise,
  output logic busy,
  output logic converting,
  output logic sar_load,
  output logic sar_step,
  output logic res_latch
);
  import daq_seq_pkg::*;

  localparam int unsigned MAX_CYC = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             acq_end;
  logic             conv_end;

  assign acq_end  = (phase_q == PH_ACQ)  && (cnt_q == CNT_W'(ACQ_CYC - 1));
  assign conv_end = (phase_q == PH_CONV) && (cnt_q == CNT_W'(CONV_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (stb_rise) begin
          phase_q <= PH_ACQ;
          cnt_q   <= '0;
        end
        PH_ACQ: if (acq_end) begin
          phase_q <= PH_CONV;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        PH_CONV: if (conv_end) begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy       = (phase_q != PH_IDLE);
  assign converting = (phase_q == PH_CONV);
  assign sar_load   = acq_end;
  assign sar_step   = converting && (cnt_q < CNT_W'(RES_BITS));
  assign res_latch  = conv_end;

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stb_rise) |=> (phase_q == PH_ACQ)); // R2
  AST_NO_RESTART_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (converting && stb_rise) |=> (phase_q != PH_ACQ)); // R8
  AST_NO_RESTART_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACQ && !acq_end && stb_rise) |=> ($past(cnt_q) + 1'b1 == cnt_q)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_latch |=> !busy); // R2

endmodule

// File: rtl/daq_sar.sv
module daq_sar #(
  parameter int unsigned RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  logic                latch,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] trial,
  output logic [RES_BITS-1:0] result
);

  localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] code_q, mask_q, res_q;
  logic [RES_BITS-1:0] code_nx, mask_nx;

  // Keep or drop the bit under test, then propose the next lower bit.
  always_comb begin
    mask_nx = mask_q >> 1;
    code_nx = (cmp_in ? code_q : (code_q & ~mask_q)) | mask_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
      res_q  <= '0;
    end else begin
      if (load) begin
        code_q <= TOP_BIT;
        mask_q <= TOP_BIT;
      end else if (step) begin
        code_q <= code_nx;
        mask_q <= mask_nx;
      end
      if (latch) res_q <= code_q;
    end
  end

  assign trial  = code_q;
  assign result = res_q;

  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q)); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(result)); // R9
  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (trial == TOP_BIT)); // R7

endmodule

// File: rtl/daq_seq_ctrl.sv
module daq_seq_ctrl #(
  parameter int unsigned CH_W      = 4,
  parameter bit          DIFF_MODE = 1'b0,
  parameter int unsigned RES_BITS  = 12,
  parameter int unsigned GRP_W     = 4,
  parameter int unsigned ACQ_CYC   = 20,
  parameter int unsigned CONV_CYC  = 16,
  localparam int unsigned N_CH     = 1 << CH_W,
  localparam int unsigned N_GRP    = RES_BITS / GRP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  logic                load_n,
  input  logic                clear_n,
  input  logic [CH_W-1:0]     addr_in,
  input  logic                mux_en,
  input  logic                cmp_in,
  output logic [CH_W-1:0]     chan_addr,
  output logic [N_CH-1:0]     chan_sel,
  output logic                busy,
  output logic [RES_BITS-1:0] dac_code,
  input  logic [N_GRP-1:0]    rd_en_n,
  output logic [RES_BITS-1:0] rd_data,
  output logic [N_GRP-1:0]    rd_drive
);

  logic                stb_q;
  logic                stb_rise, stb_fall;
  logic                converting, sar_load, sar_step, res_latch;
  logic [RES_BITS-1:0] trial, result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= strobe;
  end

  assign stb_rise = strobe & ~stb_q;
  assign stb_fall = ~strobe & stb_q;

  daq_chan_reg #(.CH_W(CH_W), .DIFF_MODE(DIFF_MODE)) u_chan (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb_fall(stb_fall),
    .load_n  (load_n),
    .clear_n (clear_n),
    .addr_in (addr_in),
    .chan    (chan_addr)
  );

  daq_phase_ctrl #(.ACQ_CYC(ACQ_CYC), .CONV_CYC(CONV_CYC), .RES_BITS(RES_BITS)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_rise  (stb_rise),
    .busy      (busy),
    .converting(converting),
    .sar_load  (sar_load),
    .sar_step  (sar_step),
    .res_latch (res_latch)
  );

  daq_sar #(.RES_BITS(RES_BITS)) u_sar (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sar_load),
    .step  (sar_step),
    .latch (res_latch),
    .cmp_in(cmp_in),
    .trial (trial),
    .result(result)
  );

  assign dac_code = converting ? trial : '0;

  for (genvar c = 0; c < N_CH; c++) begin : g_sel
    assign chan_sel[c] = mux_en && (chan_addr == CH_W'(c));
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign rd_data[g*GRP_W +: GRP_W] = rd_en_n[g] ? '0 : result[g*GRP_W +: GRP_W];
    assign rd_drive[g]               = ~rd_en_n[g];
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_sel)); // R6
  AST_SEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mux_en |-> chan_sel[chan_addr]); // R6
  AST_DAC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_code == '0)); // R7
  AST_RISE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise |=> busy); // R2

endmodule

// File: tb/daq_seq_ctrl_tb.sv
module daq_seq_ctrl_tb_top;

  localparam int ACQ  = 20;
  localparam int CONV = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0, load_n = 1'b0, clear_n = 1'b1, mux_en = 1'b0;
  logic [3:0]  addr_in = '0;
  logic [2:0]  rd_en_n = 3'b000;
  int          vin = 0;
  logic        cmp_in;
  logic [3:0]  chan_addr;
  logic [15:0] chan_sel;
  logic        busy;
  logic [11:0] dac_code, rd_data;
  logic [2:0]  rd_drive;

  int checks = 0, fails = 0, exp_ch = 0;
  int exp_q[$];
  int blen = 0;
  bit busy_seen = 0, finished = 0;

  always #5 clk = ~clk;

  assign cmp_in = (vin >= int'(dac_code));

  daq_seq_ctrl #(.ACQ_CYC(ACQ), .CONV_CYC(CONV)) dut_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .load_n(load_n), .clear_n(clear_n),
    .addr_in(addr_in), .mux_en(mux_en), .cmp_in(cmp_in), .chan_addr(chan_addr),
    .chan_sel(chan_sel), .busy(busy), .dac_code(dac_code), .rd_en_n(rd_en_n),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Monitor: measures each busy window and compares the result with the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) blen++;
      else if (busy_seen) begin
        chk("R2/R8 busy length", blen, ACQ + CONV);
        if (exp_q.size() == 0) chk("R7 unexpected result", 1, 0);
        else chk("R7 result", int'(rd_data), exp_q.pop_front());
        blen = 0;
      end
      busy_seen = busy;
    end
  end

  // Driver: sets the mode and address, meets setup and strobe width, and pushes the expected result.
  task automatic do_strobe(input bit ld_n, input bit clr_n, input int a, input int v,
                           input string req);
    @(negedge clk);
    load_n = ld_n; clear_n = clr_n; addr_in = 4'(a); vin = v;
    repeat (5) @(negedge clk);
    strobe = 1'b1;
    exp_q.push_back(v);
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    if (!clr_n) exp_ch = 0;
    else if (!ld_n) exp_ch = a;
    else exp_ch = (exp_ch >= 15) ? 0 : exp_ch + 1;
    @(negedge clk);
    chk(req, int'(chan_addr), exp_ch);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 chan", int'(chan_addr), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 dac", int'(dac_code), 0);
    chk("R1 result", int'(rd_data), 0);

    do_strobe(0, 1, 5, 1234, "R3 random load");
    wait_idle();
    do_strobe(1, 1, 0, 0, "R4 step 6");
    wait_idle();
    do_strobe(1, 1, 0, 4095, "R4 step 7");
    wait_idle();
    do_strobe(0, 1, 14, 2048, "R3 load 14");
    wait_idle();
    do_strobe(1, 1, 3, 2047, "R4 step 15");
    wait_idle();
    do_strobe(1, 1, 3, 1, "R4 wrap 0");
    wait_idle();
    do_strobe(0, 1, 9, 100, "R3 load 9");
    wait_idle();
    do_strobe(0, 0, 9, 3000, "R5 clear over load");
    wait_idle();
    do_strobe(0, 1, 11, 77, "R3 load 11");
    wait_idle();
    do_strobe(1, 0, 11, 78, "R5 clear over step");
    wait_idle();

    // R6: channel select follows mux_en
    do_strobe(0, 1, 12, 200, "R3 load 12");
    wait_idle();
    mux_en = 1'b1; #1;
    chk("R6 select on", int'(chan_sel), 1 << 12);
    @(negedge clk); mux_en = 1'b0; #1;
    chk("R6 select off", int'(chan_sel), 0);

    // R7: trial sequence for 0x500
    do_strobe(1, 1, 0, 'h500, "R4 step 13");
    repeat (ACQ + 1 - 5) @(negedge clk);
    chk("R7 first trial", int'(dac_code), 'h800);
    @(negedge clk);
    chk("R7 second trial", int'(dac_code), 'h400);
    @(negedge clk);
    chk("R7 third trial", int'(dac_code), 'h600);
    wait_idle();

    // R8: strobe pulses during acquisition and during conversion
    do_strobe(1, 1, 0, 'hA5C, "R4 step 14");
    strobe = 1'b1;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    exp_ch = 15;
    repeat (18) @(negedge clk);
    strobe = 1'b1;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    exp_ch = 0;
    @(negedge clk);
    chk("R8 chan still steps", int'(chan_addr), exp_ch);
    wait_idle();

    // R9: group gating of the stored result 0xA5C
    rd_en_n = 3'b011; #1;
    chk("R9 msb group", int'(rd_data), 'hA00);
    chk("R9 drive msb", int'(rd_drive), 3'b100);
    @(negedge clk); rd_en_n = 3'b101; #1;
    chk("R9 mid group", int'(rd_data), 'h050);
    @(negedge clk); rd_en_n = 3'b110; #1;
    chk("R9 lsb group", int'(rd_data), 'h00C);
    @(negedge clk); rd_en_n = 3'b111; #1;
    chk("R9 all off", int'(rd_data), 0);
    chk("R9 drive off", int'(rd_drive), 0);
    @(negedge clk); rd_en_n = 3'b000;

    // R9: result held while the next measurement runs
    do_strobe(0, 1, 2, 'h123, "R3 load 2");
    chk("R9 held during busy", int'(rd_data), 'hA5C);
    wait_idle();
    chk("R2 queue drained", exp_q.size(), 0);

    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

endmodule